// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out the datapath half of a bit-manipulation instruction. It picks one bit of an operand, reports whether that bit was clear through the zero flag, and produces a write-back value. The write-back value is one of four: the operand unchanged, the operand with the bit forced to one, the operand with the bit forced to zero, or the operand with the bit inverted. The other condition flags pass through untouched.

The operand is either a longword held in a register or a byte fetched from memory. The bit number comes from a register or from an immediate field. The operand kind sets how many low bits of that number are used. The caller presents everything with a one-cycle valid strobe. One clock later the unit returns the result, a write-enable and the updated flags, together with a single-cycle done pulse. Fetching and storing the memory byte is left to the surrounding sequencer.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 2'b00 (test) returns the operand unchanged and leaves the write-enable low.
- R2: Operation code 2'b11 (set) returns the operand with the selected bit forced to 1 and raises the write-enable, even when the bit was already 1.
- R3: Operation code 2'b10 (clear) returns the operand with the selected bit forced to 0 and raises the write-enable, even when the bit was already 0.
- R4: Operation code 2'b01 (change) returns the operand with the selected bit inverted and raises the write-enable.
- R5: The zero flag (flag vector bit 2) becomes the inverse of the selected bit as it was before modification, for all four operations.
- R6: Extend, negative, overflow and carry (flag vector bits 4, 3, 1, 0) are copied unchanged from the incoming flags.
- R7: With a register operand (is_mem = 0) the bit number is taken modulo 32.
- R8: With a memory operand (is_mem = 1) the bit number is taken modulo 8, and operand bits 31..8 come back unchanged.
- R9: use_imm = 1 takes the bit number from the 8-bit immediate; use_imm = 0 takes it from the 32-bit register value. The unused source has no effect.
- R10: Result, flags and write-enable appear one clock after a valid strobe, with done high for exactly that cycle. In cycles without a strobe, done and the write-enable are low and the result and flags hold.
- R11: After reset, done, the write-enable, the result and the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: operands presented this cycle |
| in_opnd | input | 32 | Operand value (byte in bits 7..0 when is_mem) |
| in_is_mem | input | 1 | 1 = memory byte operand, 0 = register longword |
| in_use_imm | input | 1 | 1 = bit number from immediate, 0 = from register |
| in_bit_reg | input | 32 | Register holding the bit number |
| in_bit_imm | input | 8 | Immediate bit number |
| in_op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| in_ccr | input | 5 | Incoming flags {X,N,Z,V,C} |
| out_done | output | 1 | One-cycle pulse with the result |
| out_result | output | 32 | Write-back value |
| out_wr_en | output | 1 | Write-back required |
| out_ccr | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
The hardest case to reach is a bit number whose discarded high bits are nonzero. These bits must be dropped differently for the two operand kinds, and the unused bit-number source must have no influence. The sweep runs bit numbers 0 to 63 under both kinds, both sources and all four operations. It adds garbage in the upper bits of the register source and of the immediate. The source that is not selected carries a conflicting value. Operand patterns are chosen so that each selected bit is seen both as 0 and as 1. This exercises set on an already-set bit and clear on an already-clear bit, both of which must still request a write.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DATA_W = 32;
    localparam int FLAG_W = 5;

    localparam int FL_C = 0;
    localparam int FL_V = 1;
    localparam int FL_Z = 2;
    localparam int FL_N = 3;
    localparam int FL_X = 4;

    typedef enum logic [1:0] {
        OP_TEST   = 2'b00,
        OP_CHANGE = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_SET    = 2'b11
    } bitop_e;

    typedef struct packed {
        logic              done;
        logic              wr_en;
        logic [DATA_W-1:0] result;
        logic [FLAG_W-1:0] ccr;
    } bitop_state_t;

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int BIDX_W = $clog2(BYTE_W)
) (
    input  logic              is_mem,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] bit_reg,
    input  logic [IMM_W-1:0]  bit_imm,
    output logic [IDX_W-1:0]  idx
);
    logic [IDX_W-1:0] raw_idx;

    always_comb begin
        // R9: pick the bit-number source
        raw_idx = use_imm ? bit_imm[IDX_W-1:0] : bit_reg[IDX_W-1:0];
        // R7 / R8: wrap by operand kind
        if (is_mem) begin
            idx = {{(IDX_W-BIDX_W){1'b0}}, raw_idx[BIDX_W-1:0]};
        end else begin
            idx = raw_idx;
        end
    end
endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign mask[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/bitop_alter.sv
module bitop_alter
    import bitop_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd,
    input  logic [WIDTH-1:0] mask,
    input  bitop_e           op,
    output logic [WIDTH-1:0] result,
    output logic             old_bit,
    output logic             wr_req
);
    always_comb begin
        old_bit = |(opnd & mask);
        wr_req  = (op != OP_TEST);
        unique case (op)
            OP_SET:    result = opnd | mask;
            OP_CLEAR:  result = opnd & ~mask;
            OP_CHANGE: result = opnd ^ mask;
            default:   result = opnd;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_opnd,
    input  logic              in_is_mem,
    input  logic              in_use_imm,
    input  logic [31:0]       in_bit_reg,
    input  logic [IMM_W-1:0]  in_bit_imm,
    input  logic [1:0]        in_op,
    input  logic [4:0]        in_ccr,
    output logic              out_done,
    output logic [31:0]       out_result,
    output logic              out_wr_en,
    output logic [4:0]        out_ccr
);
    logic [IDX_W-1:0]  sel_idx;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] alt_result;
    logic              alt_old;
    logic              alt_wr;
    bitop_e            op_sel;
    bitop_state_t      st_d, st_q;

    assign op_sel = bitop_e'(in_op);

    bitop_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IMM_W(IMM_W)) i_index (
        .is_mem  (in_is_mem),
        .use_imm (in_use_imm),
        .bit_reg (in_bit_reg),
        .bit_imm (in_bit_imm),
        .idx     (sel_idx)
    );

    bitop_mask #(.DATA_W(DATA_W)) i_mask (
        .idx  (sel_idx),
        .mask (sel_mask)
    );

    bitop_alter #(.WIDTH(DATA_W)) i_alter (
        .opnd    (in_opnd),
        .mask    (sel_mask),
        .op      (op_sel),
        .result  (alt_result),
        .old_bit (alt_old),
        .wr_req  (alt_wr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = in_valid;
        st_d.wr_en = in_valid & alt_wr;
        if (in_valid) begin
            st_d.result    = alt_result;
            st_d.ccr       = in_ccr;
            st_d.ccr[FL_Z] = ~alt_old;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_done   = st_q.done;
    assign out_wr_en  = st_q.wr_en;
    assign out_result = st_q.result;
    assign out_ccr    = st_q.ccr;

    // R10
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && !out_wr_en && $stable(out_result) && $stable(out_ccr)));

    // R1
    test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00) |=> (!out_wr_en && out_result == $past(in_opnd)));

    // R2
    modify_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b00) |=> out_wr_en);

    // R6
    flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_ccr[FL_X] == $past(in_ccr[FL_X]) && out_ccr[FL_N] == $past(in_ccr[FL_N])
                   && out_ccr[FL_V] == $past(in_ccr[FL_V]) && out_ccr[FL_C] == $past(in_ccr[FL_C])));

    // R8
    byte_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_mem) |=> out_result[31:8] == $past(in_opnd[31:8]));

    // R4
    single_bit_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(out_result ^ $past(in_opnd)) <= 1);

    // R10
    write_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_done);
endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_opnd = '0;
    logic        in_is_mem = 1'b0;
    logic        in_use_imm = 1'b0;
    logic [31:0] in_bit_reg = '0;
    logic [7:0]  in_bit_imm = '0;
    logic [1:0]  in_op = '0;
    logic [4:0]  in_ccr = '0;
    logic        out_done;
    logic [31:0] out_result;
    logic        out_wr_en;
    logic [4:0]  out_ccr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_is_mem(in_is_mem), .in_use_imm(in_use_imm), .in_bit_reg(in_bit_reg),
        .in_bit_imm(in_bit_imm), .in_op(in_op), .in_ccr(in_ccr),
        .out_done(out_done), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_ccr(out_ccr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R1 test";
            2'b11:   return "R2 set";
            2'b10:   return "R3 clear";
            default: return "R4 change";
        endcase
    endfunction

    task automatic run_one(input logic [31:0] opnd, input bit is_mem, input bit use_imm,
                           input logic [31:0] breg, input logic [7:0] bimm,
                           input logic [1:0] op, input logic [4:0] ccr);
        int unsigned num;
        int unsigned idx;
        logic [31:0] mask, exp_res;
        logic        old;
        logic [4:0]  exp_ccr;
        logic [31:0] held_res;
        logic [4:0]  held_ccr;
        // R9: chosen source; R7 modulo 32; R8 modulo 8
        num  = use_imm ? 32'(bimm) : breg;
        idx  = is_mem ? (num % 8) : (num % 32);
        mask = 32'd1 << idx;
        old  = (opnd & mask) != 0;
        case (op)
            2'b00:   exp_res = opnd;
            2'b11:   exp_res = opnd | mask;
            2'b10:   exp_res = opnd & ~mask;
            default: exp_res = opnd ^ mask;
        endcase
        exp_ccr    = ccr;
        exp_ccr[2] = ~old;

        @(negedge clk);
        in_valid = 1'b1; in_opnd = opnd; in_is_mem = is_mem; in_use_imm = use_imm;
        in_bit_reg = breg; in_bit_imm = bimm; in_op = op; in_ccr = ccr;
        @(negedge clk);
        in_valid = 1'b0; in_opnd = ~opnd; in_ccr = ~ccr; in_bit_reg = ~breg; in_bit_imm = ~bimm;
        check("R10 done pulse", 32'(out_done), 32'd1);
        check(is_mem ? {op_req(op), " R8 result"} : {op_req(op), " R7 result"}, out_result, exp_res);
        check({op_req(op), " wr_en"}, 32'(out_wr_en), (op == 2'b00) ? 32'd0 : 32'd1);
        check("R5 zero flag", 32'(out_ccr[2]), 32'(exp_ccr[2]));
        check("R6 other flags", 32'(out_ccr), 32'(exp_ccr));
        held_res = out_result;
        held_ccr = out_ccr;
        @(negedge clk);
        check("R10 done low when idle", 32'(out_done), 32'd0);
        check("R10 wr_en low when idle", 32'(out_wr_en), 32'd0);
        check("R10 result held", out_result, held_res);
        check("R10 flags held", 32'(out_ccr), 32'(held_ccr));
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5C3_3C5A;
        pats[3] = 32'h5A3C_C3A5;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 done", 32'(out_done), 32'd0);
        check("R11 wr_en", 32'(out_wr_en), 32'd0);
        check("R11 result", out_result, 32'd0);
        check("R11 flags", 32'(out_ccr), 32'd0);
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 2; k++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int o = 0; o < 4; o++) begin
                        for (int b = 0; b < 64; b++) begin
                            logic [31:0] breg;
                            logic [7:0]  bimm;
                            // R9: selected source carries garbage above its low bits,
                            // the other source carries a conflicting number
                            if (s == 1) begin
                                bimm = 8'(b) | 8'(p << 6);
                                breg = 32'(63 - b) ^ 32'h1234_5600;
                            end else begin
                                breg = (32'hDEAD_BE00 ^ 32'(p << 12)) | 32'(b);
                                bimm = 8'(63 - b);
                            end
                            run_one(pats[p], k[0], s[0], breg, bimm, o[1:0], 5'((b * 7 + p) & 31));
                        end
                    end
                end
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule